// File: doc/BRIEF.md
# Shared-Timebase Pulse Width Generator

This block produces one or two pulse-width-modulated outputs from a single time base. A small programmable divider turns the input clock into prescaled ticks. An 8-bit counter steps through 256 ticks per period, and each channel compares that counter against its own duty value. Every output rises at the start of a period and stays high for one tick more than its duty value. Because of this, a duty value of zero still gives a one-tick pulse, and the largest value holds the line high for the whole period.

Software sets the block up through a plain 32-bit register port that is read and written in one cycle. The divider setting, the run bit and the interrupt enable are common to all channels, so every channel has the same period and they all start and stop together. The software can read the running counter at any time. A new duty value is held back until the next period boundary, so no period is ever shortened or glitched. When the interrupt enable is set, an interrupt line gives a one-cycle pulse on each period boundary.

Top module: `pwm_shared_prescale`

## Requirements
- R1: After reset, every register reads zero, all outputs are low, `irq` is low and the counter reads zero.
- R2: Register map, all at word-aligned byte offsets:
  - Duty for channel c sits at 4*c, with the value in bits [7:0].
  - The control word sits at 0x50, with the divider in bits [3:0] and the run bit at bit 9.
  - The interrupt enable sits at 0x54, at bit 0.
  - The counter can be read at 0x60.
  - The unused bits of every register read zero.
  - Any other offset, including unaligned ones, reads zero, and a write there changes nothing.
- R3: While the run bit is 0, the divider and the counter are held at zero, and every output is low.
- R4: While running with divider setting p, the counter advances by one every p+1 input clocks, wraps from 255 to 0, and gives a period of 256*(p+1) clocks. The divider compares with greater-or-equal, so lowering p takes effect at once.
- R5: An output is high while the counter is less than or equal to its active duty value N, which gives N+1 ticks high. N=0 gives exactly one tick high, and N=255 keeps the output high for the whole period.
- R6: While running, a duty write takes effect only at the 255-to-0 wrap. While stopped, the active value follows the register, one cycle behind it.
- R7: When the interrupt enable is set, `irq` is high for exactly the one cycle in which the counter first reads 0 after a wrap. When the enable is clear, `irq` never goes high.
- R8: All channels share one counter, so channels with equal duty values give identical waveforms, and every output rises in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Byte address for reads and writes |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| pwm_out | output | NCH | Pulse outputs, one per channel |
| irq | output | 1 | One-cycle pulse at each period wrap when enabled |

## Verification
A wrong divider or counter state shows up on the counter readback within one prescaled tick. It then moves every output edge and the interrupt pulse by the same amount on all channels. A wrong active duty value is invisible until the counter passes the true or the faulty compare point, so the error can surface up to one full period, 256*(p+1) clocks, after the fault. This is why the bench compares the outputs on every cycle against a model across many periods and divider settings. A shadow register that loads too early changes a pulse width within the period in which the write occurs. An interrupt fault appears at the first wrap.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int PRE_W = 4;
  localparam int CNT_W = 8;
  localparam int RUN_BIT = 9;
  localparam logic [7:0] OFF_CTRL = 8'h50;
  localparam logic [7:0] OFF_IEN  = 8'h54;
  localparam logic [7:0] OFF_CNT  = 8'h60;
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [CNT_W-1:0]      cnt,
  output logic [NCH*CNT_W-1:0]  duty_flat,
  output logic [PRE_W-1:0]      pre,
  output logic                  run,
  output logic                  ien,
  output logic [DATA_W-1:0]     rdata
);
  logic [NCH-1:0][CNT_W-1:0] duty_q, duty_d;
  logic [PRE_W-1:0]          pre_q, pre_d;
  logic                      run_q, run_d;
  logic                      ien_q, ien_d;
  logic [NCH-1:0]            duty_hit;
  logic                      ctrl_hit, ien_hit;
  logic                      unused_wdata;

  assign unused_wdata = ^{wdata[DATA_W-1:RUN_BIT+1], wdata[RUN_BIT-1:CNT_W]};

  assign ctrl_hit = wr && (addr == ADDR_W'(OFF_CTRL));
  assign ien_hit  = wr && (addr == ADDR_W'(OFF_IEN));

  for (genvar c = 0; c < NCH; c++) begin : g_duty
    assign duty_hit[c] = wr && (addr == ADDR_W'(4 * c));
    always_comb begin
      duty_d[c] = duty_q[c];
      if (duty_hit[c]) duty_d[c] = wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    pre_d = pre_q;
    run_d = run_q;
    ien_d = ien_q;
    if (ctrl_hit) begin
      pre_d = wdata[PRE_W-1:0];
      run_d = wdata[RUN_BIT];
    end
    if (ien_hit) ien_d = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q <= '0;
      pre_q  <= '0;
      run_q  <= 1'b0;
      ien_q  <= 1'b0;
    end else begin
      duty_q <= duty_d;
      pre_q  <= pre_d;
      run_q  <= run_d;
      ien_q  <= ien_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(OFF_CTRL)) begin
      rdata = DATA_W'({run_q, {(RUN_BIT-PRE_W){1'b0}}, pre_q});
    end else if (addr == ADDR_W'(OFF_IEN)) begin
      rdata = DATA_W'(ien_q);
    end else if (addr == ADDR_W'(OFF_CNT)) begin
      rdata = DATA_W'(cnt);
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (addr == ADDR_W'(4 * i)) rdata = DATA_W'(duty_q[i]);
      end
    end
  end

  assign duty_flat = duty_q;
  assign pre       = pre_q;
  assign run       = run_q;
  assign ien       = ien_q;
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] pre,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic [PRE_W-1:0] div_q, div_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tick;

  assign tick = run && (div_q >= pre);
  assign wrap = tick && (cnt_q == CNT_TOP);

  always_comb begin
    div_d = div_q;
    cnt_d = cnt_q;
    if (!run) begin
      div_d = '0;
      cnt_d = '0;
    end else if (tick) begin
      div_d = '0;
      cnt_d = cnt_q + 1'b1;
    end else begin
      div_d = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else begin
      div_q <= div_d;
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             wrap,
  input  logic [CNT_W-1:0] duty,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] act,
  output logic             out
);
  logic [CNT_W-1:0] act_q, act_d;
  logic             load;

  assign load = !run || wrap;

  always_comb begin
    act_d = act_q;
    if (load) act_d = duty;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= '0;
    else        act_q <= act_d;
  end

  assign act = act_q;
  assign out = run && (cnt <= act_q);
endmodule

// File: rtl/pwm_shared_prescale.sv
module pwm_shared_prescale
  import pwm_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NCH-1:0]    pwm_out,
  output logic              irq
);
  localparam int DUTY_BITS = NCH * CNT_W;

  logic [DUTY_BITS-1:0] duty_flat;
  logic [DUTY_BITS-1:0] act_flat;
  logic [PRE_W-1:0]     pre_val;
  logic                 glob_en;
  logic                 irq_en;
  logic [CNT_W-1:0]     cnt_q;
  logic                 wrap;
  logic                 irq_q, irq_d;

  pwm_regs #(.NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .cnt(cnt_q), .duty_flat(duty_flat), .pre(pre_val), .run(glob_en),
    .ien(irq_en), .rdata(reg_rdata)
  );

  pwm_timebase tb_i (
    .clk(clk), .rst_n(rst_n), .run(glob_en), .pre(pre_val),
    .cnt(cnt_q), .wrap(wrap)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pwm_channel ch_i (
      .clk(clk), .rst_n(rst_n), .run(glob_en), .wrap(wrap),
      .duty(duty_flat[c*CNT_W +: CNT_W]), .cnt(cnt_q),
      .act(act_flat[c*CNT_W +: CNT_W]), .out(pwm_out[c])
    );
  end

  always_comb begin
    irq_d = 1'b0;
    if (glob_en && irq_en && wrap) irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;
endmodule

// File: rtl/pwm_shared_prescale_chk.sv
module pwm_shared_prescale_chk #(
  parameter int NCH = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [7:0]       cnt,
  input logic [NCH*8-1:0] act,
  input logic [NCH-1:0]   pwm_out,
  input logic             irq
);
  a_r3_stopped_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> cnt == 8'd0);

  a_r3_stopped_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> pwm_out == '0);

  a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en)) |-> (cnt == $past(cnt) || cnt == 8'($past(cnt) + 8'd1)));

  a_r6_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && cnt != 8'd0) |-> $stable(act));

  a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r7_irq_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> cnt == 8'd0);

  for (genvar c = 0; c < NCH; c++) begin : g_full
    a_r5_full_high: assert property (@(posedge clk) disable iff (!rst_n)
      (en && act[c*8 +: 8] == 8'hFF) |-> pwm_out[c]);
  end
endmodule

bind pwm_shared_prescale pwm_shared_prescale_chk #(.NCH(NCH)) chk_i (
  .clk(clk), .rst_n(rst_n), .en(glob_en), .cnt(cnt_q), .act(act_flat),
  .pwm_out(pwm_out), .irq(irq)
);

// File: tb/pwm_shared_prescale_tb_top.sv
module pwm_shared_prescale_tb_top;
  localparam int NCH = 2;
  localparam int AW  = 8;
  localparam int DW  = 32;

  logic          clk;
  logic          rst_n;
  logic          wr;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic [NCH-1:0] pout;
  logic          irq;

  int n_cmp;
  int n_bad;
  bit cmp_on;
  bit done;

  pwm_shared_prescale #(.NCH(NCH), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(wr), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .pwm_out(pout), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // reference state built from the requirements
  logic [7:0] m_duty [NCH];
  logic [7:0] m_act  [NCH];
  logic [3:0] m_pre;
  logic       m_en, m_ien, m_irq;
  logic [3:0] m_div;
  logic [7:0] m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        m_duty[c] <= 8'd0;
        m_act[c]  <= 8'd0;
      end
      m_pre <= 4'd0; m_en <= 1'b0; m_ien <= 1'b0;
      m_div <= 4'd0; m_cnt <= 8'd0; m_irq <= 1'b0;
    end else begin
      logic tk, wp;
      tk = m_en && (m_div >= m_pre);
      wp = tk && (m_cnt == 8'hFF);
      if (!m_en) begin
        m_div <= 4'd0; m_cnt <= 8'd0;
      end else if (tk) begin
        m_div <= 4'd0; m_cnt <= m_cnt + 8'd1;
      end else begin
        m_div <= m_div + 4'd1;
      end
      for (int c = 0; c < NCH; c++)
        if (!m_en || wp) m_act[c] <= m_duty[c];
      m_irq <= m_en && m_ien && wp;
      if (wr) begin
        for (int c = 0; c < NCH; c++)
          if (addr == AW'(4 * c)) m_duty[c] <= wdata[7:0];
        if (addr == 8'h50) begin m_pre <= wdata[3:0]; m_en <= wdata[9]; end
        if (addr == 8'h54) m_ien <= wdata[0];
      end
    end
  end

  function automatic logic [DW-1:0] exp_rd(logic [AW-1:0] a);
    logic [DW-1:0] r;
    r = '0;
    if (a == 8'h50) r = {22'd0, m_en, 5'd0, m_pre};
    else if (a == 8'h54) r = {31'd0, m_ien};
    else if (a == 8'h60) r = {24'd0, m_cnt};
    else
      for (int c = 0; c < NCH; c++)
        if (a == AW'(4 * c)) r = {24'd0, m_duty[c]};
    return r;
  endfunction

  function automatic logic exp_out(int c);
    return m_en && (m_cnt <= m_act[c]);
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      for (int c = 0; c < NCH; c++)
        check("R5 R8 output", DW'(pout[c]), DW'(exp_out(c)));
      check("R7 irq", DW'(irq), DW'(m_irq));
      if (addr == 8'h60) check("R4 counter read", rdata, exp_rd(addr));
      else               check("R2 register read", rdata, exp_rd(addr));
    end
  end

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic wreg(logic [AW-1:0] a, logic [DW-1:0] d);
    wr = 1'b1; addr = a; wdata = d;
    step(1);
    wr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 190000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int unsigned seed;
    int gap, hi, pulses;
    logic prev;
    seed = $urandom(32'd2718);
    n_cmp = 0; n_bad = 0; cmp_on = 1'b0; done = 1'b0;
    rst_n = 1'b0; wr = 1'b0; addr = 8'h50; wdata = '0;
    repeat (3) @(negedge clk);
    check("R1 ctrl reset", rdata, 32'd0);
    check("R1 outputs reset", DW'(pout), 32'd0);
    check("R1 irq reset", DW'(irq), 32'd0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    addr = 8'h60;
    step(1);
    check("R1 counter reset", rdata, 32'd0);
    cmp_on = 1'b1;

    // R2: readback, unused bits and holes
    wreg(8'h00, 32'hFFFF_FF5A);
    wreg(8'h50, 32'hFFFF_FDF6);
    wreg(8'h54, 32'hFFFF_FFFE);
    wreg(8'h40, 32'hFFFF_FFFF);
    wreg(8'h51, 32'hFFFF_FFFF);
    addr = 8'h00; step(1); check("R2 duty readback", rdata, 32'h5A);
    addr = 8'h50; step(1); check("R2 ctrl readback", rdata, 32'h6);
    addr = 8'h40; step(1); check("R2 hole reads zero", rdata, 32'h0);
    addr = 8'h54; step(1); check("R2 ien unchanged by hole writes", rdata, 32'h0);

    // R3: stopped with duties set
    wreg(8'h04, 32'd255);
    step(20);
    addr = 8'h60;
    step(1);
    check("R3 counter held", rdata, 32'd0);
    check("R3 outputs low", DW'(pout), 32'd0);

    // R4, R5, R7, R8: pre=1, duty0=10, duty1=255, irq on
    wreg(8'h00, 32'd10);
    wreg(8'h54, 32'd1);
    wreg(8'h50, 32'h201);
    // rising edges of channel 0
    @(negedge clk);
    prev = pout[0];
    gap = 0;
    while (!(pout[0] && !prev)) begin prev = pout[0]; @(negedge clk); end
    prev = pout[0]; hi = 1; pulses = 0; gap = 0;
    begin
      bit full;
      full = 1'b1;
      for (int k = 0; k < 600; k++) begin
        @(negedge clk);
        gap++;
        if (irq) pulses++;
        if (!pout[1]) full = 1'b0;
        if (pout[0] && !prev) break;
        if (pout[0]) hi++;
        prev = pout[0];
      end
      check("R4 period 256*(p+1)", DW'(gap), 32'd512);
      check("R5 duty 10 high clocks", DW'(hi), 32'd22);
      check("R5 duty 255 constant high", DW'(full), 32'd1);
      check("R7 one irq per period", DW'(pulses), 32'd1);
      check("R8 outputs rise together", DW'(pout), 32'd3);
    end

    // R5 duty 0 with pre=2; R6 mid-period write; R7 irq disabled
    @(posedge clk); #2;
    wreg(8'h54, 32'd0);
    wreg(8'h00, 32'd0);
    wreg(8'h50, 32'h202);
    step(1000);
    @(negedge clk);
    while (!(pout[0] && m_cnt == 8'd0)) @(negedge clk);
    hi = 0; pulses = 0;
    for (int k = 0; k < 768; k++) begin
      if (pout[0]) hi++;
      if (irq) pulses++;
      @(negedge clk);
    end
    check("R5 duty 0 one tick", DW'(hi), 32'd3);
    check("R7 no irq when disabled", DW'(pulses), 32'd0);
    @(posedge clk); #2;
    step(50);
    wreg(8'h00, 32'd200);
    step(1);
    check("R6 new duty not yet active", DW'(pout[0]), DW'(exp_out(0)));
    check("R6 still old width", DW'(pout[0] == (m_cnt == 8'd0)), 32'd1);

    // random phase
    for (int n = 0; n < 24000; n++) begin
      int unsigned r;
      r = $urandom % 16;
      if (r < 2) begin
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        int unsigned s;
        s = $urandom % 8;
        d = $urandom;
        case (s)
          0: a = 8'h00;
          1: a = 8'h04;
          2: begin a = 8'h50; d = d & 32'hFFFF_FFF3; if ($urandom % 4 != 0) d[9] = 1'b1; end
          3: a = 8'h54;
          4: a = 8'h60;
          5: a = 8'h08;
          6: a = 8'h55;
          default: a = AW'($urandom);
        endcase
        wreg(a, d);
      end else begin
        int unsigned t;
        t = $urandom % 5;
        addr = (t == 0) ? 8'h60 : (t == 1) ? 8'h50 : (t == 2) ? 8'h00 : (t == 3) ? 8'h04 : 8'h54;
        step(1);
      end
    end
    finish_run();
  end
endmodule